// File: doc/BRIEF.md
# Overdrive One-Wire Bus Master

This block drives a single-contact open-drain data line at overdrive speed for a host on the same chip. The host issues one of four commands: a bus reset with presence detection, a single write slot, a single read slot, or an eight-bit transfer. The block turns each command into line activity whose timing is derived from a clock-frequency parameter. It only ever pulls the line low through an output enable or lets it float. An external pull-up, or the wired-AND model in the bench, supplies the high level.

The returned line is brought into the clock domain through a two-flop synchroniser and sampled at fixed points inside each slot. A write-1 slot has the same line shape as a read slot, so the byte command both sends and receives. Bits go out least significant first, and the sampled bits are gathered in the same order. When a command finishes, the block raises a one-cycle completion pulse and updates the presence flag or the read data.

Top module: `owm_master`

## Requirements
- R1: Opcode 0 (reset) pulls the line low (line_oe high) for exactly 64 us, which is 3200 cycles at 50 MHz.
- R2: After a reset, presence is 1 only if the line reads low 9 us after the reset low ends. Pulses that end before this point or start after it leave presence at 0.
- R3: The released interval after the reset low lasts at least 48 us (2400 cycles) before done is raised.
- R4: Opcode 1 with cmd_data[0]=0 (write-0) holds the line low for 10 us (500 cycles).
- R5: Opcode 1 with cmd_data[0]=1 (write-1) holds the line low for 1 us (50 cycles) and then releases it.
- R6: Opcode 2 (read) holds the line low for 1 us and samples the line 1.75 us after the slot start. rd_data becomes {7'b0, sampled bit}.
- R7: Between the end of one low pulse and the start of the next there are at least 5 us (250 cycles) of released line. Consecutive slot starts within a byte are at least 15 us (750 cycles) apart.
- R8: Opcode 3 (byte) runs eight slots, sending cmd_data from bit 0 to bit 7 (1 gives a short low, 0 a long low). rd_data[i] holds the line value sampled in slot i, and a write-0 slot reports 0.
- R9: A command with cmd_valid while not busy is accepted: busy is high on the next cycle, and done rises for exactly one cycle once per command, when busy drops.
- R10: cmd_valid while busy is ignored. It causes no extra line activity and no change to presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 0 reset, 1 write bit, 2 read bit, 3 byte |
| cmd_data | input | 8 | Byte to send; bit 0 used for write bit |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Device answered the last reset |
| rd_data | output | 8 | Bits sampled by the last bit or byte command |
| line_oe | output | 1 | High pulls the bus line low |
| line_in | input | 1 | Level of the bus line |

## Verification
Resets are run against a responding device, an absent device, and presence pulses that end too early or start too late. Together these separate the 9 us sample point from a loose window. Single reads use a device that holds the line past the sample point and one that lets go before it, which pins the sample instant between release and 1.75 us. Byte transfers mix all-ones, all-zeros and seeded random patterns against random device data, so a reversed bit order, a wrong low width or a short recovery gap shows up as a wrong byte or a wrong pulse log. A command strobed mid-transfer must leave the pulse count and presence untouched.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WBIT  = 2'd1,
        OP_RBIT  = 2'd2,
        OP_BYTE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_LOW  = 2'd1,
        SL_REL  = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        K_RESET = 2'd0,
        K_LONG  = 2'd1,
        K_SHORT = 2'd2
    } kind_e;

    function automatic int ns_to_cyc(longint hz, longint ns);
        return int'((hz * ns) / 64'd1_000_000_000);
    endfunction
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
#(
    parameter int RST_LOW_C  = 3200,
    parameter int RST_HIGH_C = 2400,
    parameter int PRES_C     = 450,
    parameter int W0_C       = 500,
    parameter int SHORT_C    = 50,
    parameter int RDS_C      = 87,
    parameter int SLOT_C     = 750,
    parameter int REC_C      = 250
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  kind_e kind,
    input  logic  line_s,
    output logic  oe,
    output logic  bit_val,
    output logic  fin
);
    localparam int CW = $clog2(RST_LOW_C + RST_HIGH_C + SLOT_C + 2);

    typedef struct packed {
        slot_st_e        st;
        kind_e           kind;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   low_len;
        logic [CW-1:0]   rel_len;
        logic [CW-1:0]   samp_at;
        logic            bitv;
        logic            fin;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        unique case (q.st)
            SL_IDLE: begin
                if (start) begin
                    d.st   = SL_LOW;
                    d.cnt  = '0;
                    d.kind = kind;
                    unique case (kind)
                        K_RESET: begin
                            d.low_len = CW'(RST_LOW_C);
                            d.rel_len = CW'(RST_HIGH_C);
                            d.samp_at = CW'(PRES_C);
                        end
                        K_LONG: begin
                            d.low_len = CW'(W0_C);
                            d.rel_len = CW'(SLOT_C - W0_C);
                            d.samp_at = '0;
                        end
                        default: begin
                            d.low_len = CW'(SHORT_C);
                            d.rel_len = CW'(SLOT_C - SHORT_C);
                            d.samp_at = CW'(RDS_C - SHORT_C);
                        end
                    endcase
                end
            end
            SL_LOW: begin
                if (q.cnt == q.low_len - CW'(1)) begin
                    d.st  = SL_REL;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            SL_REL: begin
                if (q.cnt == q.samp_at) d.bitv = (q.kind != K_LONG) && line_s;
                if (q.cnt == q.rel_len - CW'(1)) begin
                    d.st  = SL_IDLE;
                    d.fin = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SL_IDLE;
            q.kind <= K_RESET;
            q.bitv <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign oe      = (q.st == SL_LOW);
    assign bit_val = q.bitv;
    assign fin     = q.fin;

    // checker state: length of current low pulse and of current release
    logic [CW-1:0] lo_run_q, hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= CW'(REC_C);
        end else begin
            lo_run_q <= oe ? lo_run_q + CW'(1) : '0;
            if (oe)                     hi_run_q <= '0;
            else if (hi_run_q < CW'(REC_C)) hi_run_q <= hi_run_q + CW'(1);
        end
    end

    // R1 R4 R5
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> (lo_run_q == CW'(RST_LOW_C) || lo_run_q == CW'(W0_C) ||
                       lo_run_q == CW'(SHORT_C)));

    // R7
    recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (hi_run_q >= CW'(REC_C)));
endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter longint CLK_HZ      = 50_000_000,
    parameter int     RST_LOW_NS  = 64_000,
    parameter int     RST_HIGH_NS = 48_000,
    parameter int     PRES_NS     = 9_000,
    parameter int     W0_NS       = 10_000,
    parameter int     SHORT_NS    = 1_000,
    parameter int     RDS_NS      = 1_750,
    parameter int     SLOT_NS     = 15_000,
    parameter int     REC_NS      = 5_000,
    parameter int     SYNC_STAGES = 2,
    parameter int     DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          done,
    output logic          presence,
    output logic [DW-1:0] rd_data,
    output logic          line_oe,
    input  logic          line_in
);
    localparam int RST_LOW_C  = ns_to_cyc(CLK_HZ, RST_LOW_NS);
    localparam int RST_HIGH_C = ns_to_cyc(CLK_HZ, RST_HIGH_NS);
    localparam int PRES_C     = ns_to_cyc(CLK_HZ, PRES_NS);
    localparam int W0_C       = ns_to_cyc(CLK_HZ, W0_NS);
    localparam int SHORT_C    = ns_to_cyc(CLK_HZ, SHORT_NS);
    localparam int RDS_C      = ns_to_cyc(CLK_HZ, RDS_NS);
    localparam int SLOT_C     = ns_to_cyc(CLK_HZ, SLOT_NS);
    localparam int REC_C      = ns_to_cyc(CLK_HZ, REC_NS);
    localparam int IW         = $clog2(DW);
    localparam int HW         = $clog2(RST_HIGH_C + 2);

    typedef struct packed {
        logic          busy;
        op_e           op;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic [IW-1:0] idx;
        logic          kick;
        logic          pres;
        logic [DW-1:0] rd;
        logic          done;
    } ctl_t;

    ctl_t  d, q;
    logic  line_s, slot_oe, slot_bit, slot_fin;
    kind_e slot_kind;

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_in),
        .d_out (line_s)
    );

    always_comb begin
        unique case (q.op)
            OP_RESET: slot_kind = K_RESET;
            OP_RBIT:  slot_kind = K_SHORT;
            default:  slot_kind = q.tx[0] ? K_SHORT : K_LONG;
        endcase
    end

    owm_slot #(
        .RST_LOW_C  (RST_LOW_C),
        .RST_HIGH_C (RST_HIGH_C),
        .PRES_C     (PRES_C),
        .W0_C       (W0_C),
        .SHORT_C    (SHORT_C),
        .RDS_C      (RDS_C),
        .SLOT_C     (SLOT_C),
        .REC_C      (REC_C)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q.kick),
        .kind    (slot_kind),
        .line_s  (line_s),
        .oe      (slot_oe),
        .bit_val (slot_bit),
        .fin     (slot_fin)
    );

    always_comb begin
        logic [DW-1:0] rx_new;
        d      = q;
        d.done = 1'b0;
        d.kick = 1'b0;
        rx_new = {slot_bit, q.rx[DW-1:1]};
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy = 1'b1;
                d.op   = op_e'(cmd_op);
                d.tx   = (op_e'(cmd_op) == OP_WBIT) ? DW'(cmd_data[0]) : cmd_data;
                d.rx   = '0;
                d.idx  = '0;
                d.kick = 1'b1;
            end
        end else if (slot_fin) begin
            unique case (q.op)
                OP_RESET: begin
                    d.pres = ~slot_bit;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
                OP_WBIT, OP_RBIT: begin
                    d.rd   = DW'(slot_bit);
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
                default: begin
                    d.rx = rx_new;
                    if (q.idx == IW'(DW - 1)) begin
                        d.rd   = rx_new;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx  = q.idx + IW'(1);
                        d.tx   = q.tx >> 1;
                        d.kick = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.op <= OP_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign presence = q.pres;
    assign rd_data  = q.rd;
    assign line_oe  = slot_oe;

    // checker state: released cycles since the line was last pulled
    logic [HW-1:0] rel_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            rel_run_q <= '0;
        else if (slot_oe)                      rel_run_q <= '0;
        else if (rel_run_q < HW'(RST_HIGH_C))  rel_run_q <= rel_run_q + HW'(1);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_fin) |=> (busy && $stable(presence)));

    // R3
    reset_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op == OP_RESET) |-> (rel_run_q >= HW'(RST_HIGH_C)));
endmodule

// File: tb/owm_master_bench.sv
module owm_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       busy, done, presence, line_oe;
    logic [7:0] rd_data;
    logic       slave_low;
    logic       line_w;

    always #10 clk = ~clk;

    assign line_w = ~(line_oe | slave_low);

    owm_master u_owm_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .done      (done),
        .presence  (presence),
        .rd_data   (rd_data),
        .line_oe   (line_oe),
        .line_in   (line_w)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    // behavioural device on the wire
    logic [7:0] sbits = 8'hFF;
    int  sidx = 0, s_lolen = 0, pull_cnt = 0, pres_wait = 0;
    bit  pres_en = 1;
    int  pres_dly = 100, pres_len = 500, hold = 200;
    logic s_oe_p = 1'b0;

    assign slave_low = (pull_cnt != 0);

    always @(posedge clk) begin
        if (cmd_valid && !busy) sidx <= 0;
        if (pull_cnt != 0) pull_cnt <= pull_cnt - 1;
        if (pres_wait > 1) pres_wait <= pres_wait - 1;
        else if (pres_wait == 1) begin
            pres_wait <= 0;
            pull_cnt  <= pres_len;
        end
        if (line_oe && !s_oe_p) begin
            s_lolen <= 1;
            if (!sbits[sidx]) pull_cnt <= hold;
            sidx <= (sidx + 1) % 8;
        end else if (line_oe) begin
            s_lolen <= s_lolen + 1;
        end else if (s_oe_p && s_lolen > 1500) begin
            sidx <= 0;
            if (pres_en) pres_wait <= pres_dly;
        end
        s_oe_p <= line_oe;
    end

    // line monitor
    int cyc = 0, cur_lo = 0, cur_hi = 0, n_lo = 0, gap_min = 1 << 30;
    int last_rise = -1, per_min = 1 << 30, fall_t = 0, done_t = 0, n_done = 0;
    bit seen_low = 0;
    int lo_log[16];
    logic m_oe_p = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (line_oe) begin
            if (!m_oe_p) begin
                if (seen_low && cur_hi < gap_min) gap_min = cur_hi;
                if (last_rise >= 0 && (cyc - last_rise) < per_min) per_min = cyc - last_rise;
                last_rise = cyc;
                cur_lo = 0;
            end
            cur_lo = cur_lo + 1;
        end else begin
            if (m_oe_p) begin
                if (n_lo < 16) lo_log[n_lo] = cur_lo;
                n_lo = n_lo + 1;
                cur_hi = 0;
                fall_t = cyc;
                seen_low = 1;
            end
            cur_hi = cur_hi + 1;
        end
        if (done) begin
            n_done = n_done + 1;
            done_t = cyc;
        end
        m_oe_p = line_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_low(input bit b);
        return b ? 50 : 500;
    endfunction

    function automatic logic [7:0] exp_rx(input logic [7:0] tx, input logic [7:0] dev);
        return tx & dev;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] data);
        n_lo = 0; n_done = 0; last_rise = -1; per_min = 1 << 30;
        @(negedge clk);
        cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(done === 1'b0 && n_done == 1, "R9 single done pulse", n_done, 1);
    endtask

    initial begin
        logic [7:0] tx, dv;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk(line_oe === 0 && busy === 0 && done === 0 && presence === 0 && rd_data === 8'h00,
            "reset state", int'({line_oe, busy, done, presence}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R3 responding device
        run_cmd(2'd0, 8'h00);
        chk(lo_log[0] == 3200, "R1 reset low width", lo_log[0], 3200);
        chk(presence === 1'b1, "R2 presence seen", int'(presence), 1);
        chk(done_t - fall_t >= 2400, "R3 reset high time", done_t - fall_t, 2400);

        // R2 absent device
        pres_en = 0;
        run_cmd(2'd0, 8'h00);
        chk(presence === 1'b0, "R2 no device", int'(presence), 0);
        // R2 late pulse
        pres_en = 1; pres_dly = 550; pres_len = 400;
        run_cmd(2'd0, 8'h00);
        chk(presence === 1'b0, "R2 late pulse", int'(presence), 0);
        // R2 early pulse
        pres_dly = 100; pres_len = 200;
        run_cmd(2'd0, 8'h00);
        chk(presence === 1'b0, "R2 early pulse", int'(presence), 0);
        pres_len = 500;

        // R4 R5 single writes
        sbits = 8'hFF;
        run_cmd(2'd1, 8'h00);
        chk(lo_log[0] == 500, "R4 write-0 low", lo_log[0], 500);
        chk(rd_data === 8'h00, "R4 write-0 result", int'(rd_data), 0);
        run_cmd(2'd1, 8'h01);
        chk(lo_log[0] == 50, "R5 write-1 low", lo_log[0], 50);

        // R6 reads
        sbits = 8'h00; hold = 200;
        run_cmd(2'd2, 8'h00);
        chk(rd_data === 8'h00 && lo_log[0] == 50, "R6 read zero", int'(rd_data), 0);
        sbits = 8'hFF;
        run_cmd(2'd2, 8'h00);
        chk(rd_data === 8'h01, "R6 read one", int'(rd_data), 1);
        sbits = 8'h00; hold = 60;
        run_cmd(2'd2, 8'h00);
        chk(rd_data === 8'h01, "R6 sample after early release", int'(rd_data), 1);
        hold = 200;

        // R8 directed bytes
        sbits = 8'hA5;
        run_cmd(2'd3, 8'hFF);
        chk(rd_data === 8'hA5, "R8 read byte", int'(rd_data), 8'hA5);
        chk(n_lo == 8, "R8 slot count", n_lo, 8);
        sbits = 8'hFF;
        run_cmd(2'd3, 8'h00);
        chk(rd_data === 8'h00 && lo_log[7] == 500, "R8 write zeros", int'(rd_data), 0);
        chk(per_min >= 750, "R7 slot period", per_min, 750);

        // R8 R7 random bytes
        for (int k = 0; k < 10; k++) begin
            tx = 8'($urandom()); dv = 8'($urandom());
            sbits = dv;
            run_cmd(2'd3, tx);
            chk(rd_data === exp_rx(tx, dv), "R8 random byte", int'(rd_data), int'(exp_rx(tx, dv)));
            for (int b = 0; b < 8; b++)
                chk(lo_log[b] == exp_low(tx[b]), "R8 bit order low width", lo_log[b], exp_low(tx[b]));
            chk(per_min >= 750, "R7 slot period", per_min, 750);
        end
        chk(gap_min >= 250, "R7 recovery gap", gap_min, 250);

        // R10 command during busy
        sbits = 8'h3C;
        n_lo = 0; n_done = 0;
        @(negedge clk);
        cmd_op = 2'd3; cmd_data = 8'hFF; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (1000) @(negedge clk);
        cmd_op = 2'd0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        repeat (400) @(negedge clk);
        chk(busy === 1'b0 && n_lo == 8, "R10 no extra activity", n_lo, 8);
        chk(presence === 1'b0, "R10 presence kept", int'(presence), 0);
        chk(rd_data === 8'h3C, "R10 byte intact", int'(rd_data), 8'h3C);

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule